// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits beside one processor port and keeps a record of every memory request that has been issued but not yet completed. Each entry is held in one of two small tables, one for read-class requests and one for write-class requests, and each entry is keyed by the cache line address of its request. When a new request is presented, the tracker decides in the same cycle whether to take it, reject it because its line is already in flight, reject it because there is no room, or reject it because the access runs past the end of its cache block. An accepted request receives a fresh identifier in that same cycle.

Completions arrive as separate read and write strobes, each carrying a line address. A completion frees the matching entry of its own table. A completion that matches nothing raises a sticky protocol error. A watchdog starts with the first accepted request. While anything is outstanding it samples the age of every entry once per threshold interval, and it raises a sticky deadlock flag if any entry has become too old. Four counters record aliased rejections, split by the kind of the new request and the kind of the entry that blocked it.

Top module: `req_tracker`

## Requirements
- R1: Type codes 2 (store), 3 (read-modify-write read), 4 (read-modify-write write), 5 (locked read) and 6 (locked write) go to the write table. Codes 0 (load), 1 (instruction fetch) and 7 go to the read table. The line address is `req_addr` with the low log2(BLK_BYTES) bits dropped.
- R2: A valid request whose line is held in either table is rejected with `rsp_alias`, whatever its type, and is not stored. No two valid entries ever share a line address.
- R3: A request that is not aliased is rejected with `rsp_full` when the outstanding count is at or above MAX_OUT, or when its target table has no free slot.
- R4: A request whose offset within the block plus `req_len` exceeds BLK_BYTES is rejected with `rsp_span_err`. This check has priority over alias and full. A sum exactly equal to BLK_BYTES is allowed.
- R5: While `req_valid` is high, exactly one of `rsp_accept`, `rsp_alias`, `rsp_full`, `rsp_span_err` is high. While it is low, none is.
- R6: `rsp_id` is 0 after reset, shows the identifier given to an acceptance in that same cycle, and advances by one after each acceptance only.
- R7: A read (write) completion whose line is present in the read (write) table frees that entry at the clock edge. From the next cycle the line can be accepted again.
- R8: A read (write) completion whose line is not present in the read (write) table sets `proto_err`, which stays high until reset.
- R9: The internal outstanding count always equals the number of valid entries in both tables.
- R10: `now` is assumed to advance by one each cycle. The watchdog arms on an acceptance while it is idle. It then checks once every THRESH cycles, the first check falling THRESH cycles after the arming acceptance. At a check, `deadlock` is set (sticky) if any entry present has `now` minus its issue time at least THRESH.
- R11: Each aliased rejection increments one of four counters. A new request is read-kind for codes 0, 1, 3, 5 and 7 and write-kind otherwise. The blocker is write-kind if the line sits in the write table, which is checked first. The counters are `stall_rd_rd`, `stall_rd_wr`, `stall_wr_rd` and `stall_wr_wr`, named new kind then blocker kind.
- R12: At a check, if no request will remain outstanding after that cycle, the watchdog disarms. The next acceptance re-arms it with a fresh full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_type | input | 3 | Request type code |
| req_addr | input | ADDR_W | Physical byte address |
| req_len | input | OFS_W+1 | Access length in bytes |
| now | input | TIME_W | Free-running cycle count |
| rd_done | input | 1 | Read completion strobe |
| rd_done_line | input | LINE_W | Line address of read completion |
| wr_done | input | 1 | Write completion strobe |
| wr_done_line | input | LINE_W | Line address of write completion |
| rsp_accept | output | 1 | Request taken |
| rsp_alias | output | 1 | Rejected: line already outstanding |
| rsp_full | output | 1 | Rejected: no room |
| rsp_span_err | output | 1 | Rejected: access crosses block end |
| rsp_id | output | ID_W | Identifier of the accepted request |
| deadlock | output | 1 | Sticky age-limit violation |
| proto_err | output | 1 | Sticky unmatched completion |
| stall_rd_rd | output | CNT_W | Read blocked by read entry |
| stall_rd_wr | output | CNT_W | Read blocked by write entry |
| stall_wr_rd | output | CNT_W | Write blocked by read entry |
| stall_wr_wr | output | CNT_W | Write blocked by write entry |

## Verification
The assertions assume that `now` moves by one per cycle. They also assume that a completion never names a line held twice, which the tracker itself prevents. The stimulus drives `now` from the bench's own cycle count. Most completions are drawn from lines the reference model knows to be outstanding, so the sticky protocol flag is only provoked in a final phase. Requests use a pool of a few lines, which keeps aliasing and full conditions frequent. Long idle and held-entry phases push the watchdog through disarm, re-arm and a timed deadlock.

// File: rtl/req_tracker.sv
module req_tracker #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int RD_N      = 4,
  parameter int WR_N      = 4,
  parameter int MAX_OUT   = 6,
  parameter int THRESH    = 64,
  parameter int TIME_W    = 16,
  parameter int ID_W      = 16,
  parameter int CNT_W     = 16,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int LINE_W   = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OFS_W:0]    req_len,
  input  logic [TIME_W-1:0] now,
  input  logic              rd_done,
  input  logic [LINE_W-1:0] rd_done_line,
  input  logic              wr_done,
  input  logic [LINE_W-1:0] wr_done_line,
  output logic              rsp_accept,
  output logic              rsp_alias,
  output logic              rsp_full,
  output logic              rsp_span_err,
  output logic [ID_W-1:0]   rsp_id,
  output logic              deadlock,
  output logic              proto_err,
  output logic [CNT_W-1:0]  stall_rd_rd,
  output logic [CNT_W-1:0]  stall_rd_wr,
  output logic [CNT_W-1:0]  stall_wr_rd,
  output logic [CNT_W-1:0]  stall_wr_wr
);

  localparam int RD_IW = (RD_N > 1) ? $clog2(RD_N) : 1;
  localparam int WR_IW = (WR_N > 1) ? $clog2(WR_N) : 1;
  localparam int OUT_W = $clog2(RD_N + WR_N + 1);
  localparam int WD_W  = $clog2(THRESH + 1);

  logic [RD_N-1:0]   rd_v, rd_hit, rd_kill, rd_old;
  logic [WR_N-1:0]   wr_v, wr_hit, wr_kill, wr_old;
  logic [LINE_W-1:0] rd_line [RD_N];
  logic [LINE_W-1:0] wr_line [WR_N];
  logic [TIME_W-1:0] rd_t [RD_N];
  logic [TIME_W-1:0] wr_t [WR_N];
  logic [RD_IW-1:0]  rd_slot;
  logic [WR_IW-1:0]  wr_slot;
  logic              rd_room, wr_room;

  logic [OUT_W-1:0]  cnt, cnt_nx;
  logic [ID_W-1:0]   id_q;
  logic              wd_on;
  logic [WD_W-1:0]   wd_cnt;
  logic              dead_q, perr_q;
  logic [CNT_W-1:0]  st_rr, st_rw, st_wr, st_ww;

  wire [LINE_W-1:0] req_line = req_addr[ADDR_W-1:OFS_W];
  wire to_wr  = (req_type >= 3'd2) && (req_type <= 3'd6);
  wire new_wr = (req_type == 3'd2) || (req_type == 3'd4) || (req_type == 3'd6);
  wire [OFS_W+1:0] span_end = {2'b00, req_addr[OFS_W-1:0]} + {1'b0, req_len};
  wire span_bad = span_end > (OFS_W+2)'(BLK_BYTES);
  wire blk_wr   = |wr_hit;
  wire any_hit  = blk_wr | (|rd_hit);
  wire no_room  = (cnt >= OUT_W'(MAX_OUT)) || (to_wr ? !wr_room : !rd_room);

  assign rsp_span_err = req_valid && span_bad;
  assign rsp_alias    = req_valid && !span_bad && any_hit;
  assign rsp_full     = req_valid && !span_bad && !any_hit && no_room;
  assign rsp_accept   = req_valid && !span_bad && !any_hit && !no_room;

  always_comb begin
    rd_hit = '0; rd_kill = '0; rd_old = '0; rd_room = 1'b0; rd_slot = '0;
    for (int i = RD_N - 1; i >= 0; i--) begin
      rd_hit[i]  = rd_v[i] && (rd_line[i] == req_line);
      rd_kill[i] = rd_v[i] && (rd_line[i] == rd_done_line);
      rd_old[i]  = rd_v[i] && ((now - rd_t[i]) >= TIME_W'(THRESH));
      if (!rd_v[i]) begin
        rd_room = 1'b1;
        rd_slot = RD_IW'(i);
      end
    end
  end

  always_comb begin
    wr_hit = '0; wr_kill = '0; wr_old = '0; wr_room = 1'b0; wr_slot = '0;
    for (int i = WR_N - 1; i >= 0; i--) begin
      wr_hit[i]  = wr_v[i] && (wr_line[i] == req_line);
      wr_kill[i] = wr_v[i] && (wr_line[i] == wr_done_line);
      wr_old[i]  = wr_v[i] && ((now - wr_t[i]) >= TIME_W'(THRESH));
      if (!wr_v[i]) begin
        wr_room = 1'b1;
        wr_slot = WR_IW'(i);
      end
    end
  end

  wire acc_rd = rsp_accept && !to_wr;
  wire acc_wr = rsp_accept && to_wr;
  wire rd_fin = rd_done && (|rd_kill);
  wire wr_fin = wr_done && (|wr_kill);
  wire stale  = (|rd_old) || (|wr_old);
  wire wd_hit = wd_on && (wd_cnt == '0);

  assign cnt_nx = cnt + OUT_W'(rsp_accept) - OUT_W'(rd_fin) - OUT_W'(wr_fin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v <= '0;
      wr_v <= '0;
    end else begin
      for (int i = 0; i < RD_N; i++) begin
        if (rd_done && rd_kill[i]) rd_v[i] <= 1'b0;
        if (acc_rd && (rd_slot == RD_IW'(i))) rd_v[i] <= 1'b1;
      end
      for (int i = 0; i < WR_N; i++) begin
        if (wr_done && wr_kill[i]) wr_v[i] <= 1'b0;
        if (acc_wr && (wr_slot == WR_IW'(i))) wr_v[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < RD_N; i++)
      if (acc_rd && (rd_slot == RD_IW'(i))) begin
        rd_line[i] <= req_line;
        rd_t[i]    <= now;
      end
    for (int i = 0; i < WR_N; i++)
      if (acc_wr && (wr_slot == WR_IW'(i))) begin
        wr_line[i] <= req_line;
        wr_t[i]    <= now;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      id_q   <= '0;
      wd_on  <= 1'b0;
      wd_cnt <= '0;
      dead_q <= 1'b0;
      perr_q <= 1'b0;
      st_rr  <= '0;
      st_rw  <= '0;
      st_wr  <= '0;
      st_ww  <= '0;
    end else begin
      cnt <= cnt_nx;
      if (rsp_accept) id_q <= id_q + 1'b1;
      if ((rd_done && !(|rd_kill)) || (wr_done && !(|wr_kill))) perr_q <= 1'b1;
      if (wd_hit) begin
        if (stale) dead_q <= 1'b1;
        if (cnt_nx != '0) wd_cnt <= WD_W'(THRESH - 1);
        else              wd_on  <= 1'b0;
      end else if (wd_on) begin
        wd_cnt <= wd_cnt - 1'b1;
      end else if (rsp_accept) begin
        wd_on  <= 1'b1;
        wd_cnt <= WD_W'(THRESH - 1);
      end
      if (rsp_alias)
        case ({new_wr, blk_wr})
          2'b00:   st_rr <= st_rr + 1'b1;
          2'b01:   st_rw <= st_rw + 1'b1;
          2'b10:   st_wr <= st_wr + 1'b1;
          default: st_ww <= st_ww + 1'b1;
        endcase
    end
  end

  assign rsp_id      = id_q;
  assign deadlock    = dead_q;
  assign proto_err   = perr_q;
  assign stall_rd_rd = st_rr;
  assign stall_rd_wr = st_rw;
  assign stall_wr_rd = st_wr;
  assign stall_wr_wr = st_ww;

endmodule

// File: rtl/req_tracker_chk.sv
module req_tracker_chk #(
  parameter int RD_N    = 4,
  parameter int WR_N    = 4,
  parameter int MAX_OUT = 6,
  parameter int LINE_W  = 26,
  parameter int OUT_W   = 4,
  parameter int ID_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_accept,
  input logic              rsp_alias,
  input logic              rsp_full,
  input logic              rsp_span_err,
  input logic [ID_W-1:0]   rsp_id,
  input logic              deadlock,
  input logic              proto_err,
  input logic [OUT_W-1:0]  cnt,
  input logic [RD_N-1:0]   rd_v,
  input logic [WR_N-1:0]   wr_v,
  input logic [LINE_W-1:0] rd_line [RD_N],
  input logic [LINE_W-1:0] wr_line [WR_N]
);

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < RD_N; i++) begin
      for (int j = i + 1; j < RD_N; j++)
        if (rd_v[i] && rd_v[j] && rd_line[i] == rd_line[j]) dup = 1'b1;
      for (int j = 0; j < WR_N; j++)
        if (rd_v[i] && wr_v[j] && rd_line[i] == wr_line[j]) dup = 1'b1;
    end
    for (int i = 0; i < WR_N; i++)
      for (int j = i + 1; j < WR_N; j++)
        if (wr_v[i] && wr_v[j] && wr_line[i] == wr_line[j]) dup = 1'b1;
  end

  p_one_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({rsp_accept, rsp_alias, rsp_full, rsp_span_err}));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(rsp_accept || rsp_alias || rsp_full || rsp_span_err));
  p_count_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) == $countones(rd_v) + $countones(wr_v));
  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= MAX_OUT);
  p_unique_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);
  p_id_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |=> rsp_id == $past(rsp_id) + 1'b1);
  p_id_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_accept |=> $stable(rsp_id));
  p_dead_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);
  p_perr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind req_tracker req_tracker_chk #(
  .RD_N(RD_N), .WR_N(WR_N), .MAX_OUT(MAX_OUT), .LINE_W(LINE_W),
  .OUT_W(OUT_W), .ID_W(ID_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .rsp_accept(rsp_accept), .rsp_alias(rsp_alias), .rsp_full(rsp_full),
  .rsp_span_err(rsp_span_err), .rsp_id(rsp_id), .deadlock(deadlock),
  .proto_err(proto_err), .cnt(cnt), .rd_v(rd_v), .wr_v(wr_v),
  .rd_line(rd_line), .wr_line(wr_line)
);

// File: tb/test_req_tracker.sv
module test_req_tracker;
  localparam int CLK_NS  = 10;
  localparam int BLK     = 64;
  localparam int RD_N    = 4;
  localparam int WR_N    = 4;
  localparam int MAX_OUT = 6;
  localparam int THRESH  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_type = '0;
  logic [31:0] req_addr = '0;
  logic [6:0]  req_len = '0;
  logic [15:0] now = '0;
  logic        rd_done = 1'b0, wr_done = 1'b0;
  logic [25:0] rd_done_line = '0, wr_done_line = '0;
  logic        rsp_accept, rsp_alias, rsp_full, rsp_span_err;
  logic [15:0] rsp_id;
  logic        deadlock, proto_err;
  logic [15:0] stall_rd_rd, stall_rd_wr, stall_wr_rd, stall_wr_wr;

  req_tracker i_req_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_len(req_len), .now(now),
    .rd_done(rd_done), .rd_done_line(rd_done_line),
    .wr_done(wr_done), .wr_done_line(wr_done_line),
    .rsp_accept(rsp_accept), .rsp_alias(rsp_alias), .rsp_full(rsp_full),
    .rsp_span_err(rsp_span_err), .rsp_id(rsp_id), .deadlock(deadlock),
    .proto_err(proto_err), .stall_rd_rd(stall_rd_rd), .stall_rd_wr(stall_rd_wr),
    .stall_wr_rd(stall_wr_rd), .stall_wr_wr(stall_wr_wr)
  );

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  int cyc = 0;
  int rd_tab[int];
  int wr_tab[int];
  int nid = 0;
  int st[4];
  bit m_dead = 0, m_perr = 0, wd_on = 0;
  int wd_cnt = 0;

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One clock: drive at negedge, compare, advance the reference model
  task automatic step(bit v, int typ, int addr, int len, bit rd, int rdl, bit wr, int wrl);
    int line, total;
    bit span, towr, newwr, inw, inr, e_alias, e_full, e_acc, e_span, fire, stale;
    @(negedge clk);
    req_valid = v; req_type = 3'(typ); req_addr = 32'(addr); req_len = 7'(len);
    rd_done = rd; rd_done_line = 26'(rdl); wr_done = wr; wr_done_line = 26'(wrl);
    now = 16'(cyc);
    #1;
    line  = addr / BLK;
    span  = ((addr % BLK) + len) > BLK;                  // R4
    towr  = (typ >= 2 && typ <= 6);                       // R1
    newwr = (typ == 2 || typ == 4 || typ == 6);           // R11
    inw   = wr_tab.exists(line);
    inr   = rd_tab.exists(line);
    total = rd_tab.num() + wr_tab.num();
    e_span  = v && span;
    e_alias = v && !span && (inw || inr);                 // R2
    e_full  = v && !span && !(inw || inr) &&
              (total >= MAX_OUT || (towr ? wr_tab.num() >= WR_N : rd_tab.num() >= RD_N)); // R3
    e_acc   = v && !span && !(inw || inr) && !e_full;
    check("R4", "rsp_span_err", int'(rsp_span_err), int'(e_span));
    check("R2", "rsp_alias", int'(rsp_alias), int'(e_alias));
    check("R3", "rsp_full", int'(rsp_full), int'(e_full));
    check("R1/R5", "rsp_accept", int'(rsp_accept), int'(e_acc));
    check("R6", "rsp_id", int'(rsp_id), nid & 16'hffff);
    check("R10", "deadlock", int'(deadlock), int'(m_dead));
    check("R8", "proto_err", int'(proto_err), int'(m_perr));
    check("R11", "stall_rd_rd", int'(stall_rd_rd), st[0]);
    check("R11", "stall_rd_wr", int'(stall_rd_wr), st[1]);
    check("R11", "stall_wr_rd", int'(stall_wr_rd), st[2]);
    check("R11", "stall_wr_wr", int'(stall_wr_wr), st[3]);
    // model update for the coming edge
    fire  = wd_on && wd_cnt == 0;
    stale = 0;
    foreach (rd_tab[k]) if (cyc - rd_tab[k] >= THRESH) stale = 1;
    foreach (wr_tab[k]) if (cyc - wr_tab[k] >= THRESH) stale = 1;
    if (rd) begin if (rd_tab.exists(rdl)) rd_tab.delete(rdl); else m_perr = 1; end  // R7 R8
    if (wr) begin if (wr_tab.exists(wrl)) wr_tab.delete(wrl); else m_perr = 1; end
    if (e_acc) begin
      if (towr) wr_tab[line] = cyc; else rd_tab[line] = cyc;
      nid++;
    end
    if (e_alias) st[{newwr, inw}]++;
    total = rd_tab.num() + wr_tab.num();                  // R9
    if (fire) begin                                       // R10 R12
      if (stale) m_dead = 1;
      if (total > 0) wd_cnt = THRESH - 1; else wd_on = 0;
    end else if (wd_on) wd_cnt--;
    else if (e_acc) begin wd_on = 1; wd_cnt = THRESH - 1; end
    cyc++;
  endtask

  task automatic req(int typ, int line, int ofs, int len);
    step(1, typ, line * BLK + ofs, len, 0, 0, 0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    int q[$];
    foreach (rd_tab[k]) q.push_back(k);
    foreach (q[i]) step(0, 0, 0, 0, 1, q[i], 0, 0);
    q.delete();
    foreach (wr_tab[k]) q.push_back(k);
    foreach (q[i]) step(0, 0, 0, 0, 0, 0, 1, q[i]);
  endtask

  initial begin
    #(CLK_NS * 200000);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); now = 16'(cyc); cyc++;
    end
    @(negedge clk); rst_n = 1'b1; now = 16'(cyc); cyc++;
    #1;
    // reset state (R5 R6 R8 R10)
    check("R6", "reset rsp_id", int'(rsp_id), 0);
    check("R10", "reset deadlock", int'(deadlock), 0);
    check("R8", "reset proto_err", int'(proto_err), 0);
    check("R5", "reset status", int'({rsp_accept, rsp_alias, rsp_full, rsp_span_err}), 0);

    // directed: R1 R2 R11
    req(0, 1, 4, 8);        // load line 1 accepted to read table
    req(2, 1, 0, 4);        // store on read line: alias, write-kind blocked by read
    req(2, 2, 0, 4);        // store line 2 accepted to write table
    req(0, 2, 8, 4);        // load on write line: alias, read blocked by write
    req(5, 2, 0, 4);        // locked read (read-kind) blocked by write
    req(6, 1, 0, 4);        // locked write blocked by read
    // R4 boundary
    req(0, 3, 60, 8);       // crosses block end
    req(1, 3, 60, 4);       // ends exactly on boundary: accepted
    req(2, 2, 63, 2);       // span error beats alias
    // R3 full cases
    req(0, 4, 0, 1);
    req(0, 5, 0, 1);        // read table now 4 entries
    req(0, 6, 0, 1);        // read table has no slot
    req(3, 7, 0, 1);        // rmw read to write table, count 6
    req(4, 8, 0, 1);        // count at MAX_OUT
    // R7 completions, same-cycle release and re-accept
    step(1, 0, 1 * BLK, 4, 1, 1, 1, 2);   // line 1 still aliased this cycle
    req(0, 1, 0, 4);                      // now accepted
    req(7, 9, 0, 4);                      // code 7 -> read table, which is full
    drain();

    // random traffic over a small line pool
    for (int n = 0; n < 3000; n++) begin
      int rq[$], wq[$];
      bit v, rd, wr;
      int rdl, wrl;
      foreach (rd_tab[k]) rq.push_back(k);
      foreach (wr_tab[k]) wq.push_back(k);
      v  = ($urandom_range(0, 9) < 6);
      rd = (rq.size() > 0) && ($urandom_range(0, 1) == 1);
      wr = (wq.size() > 0) && ($urandom_range(0, 1) == 1);
      rdl = rd ? rq[$urandom_range(0, rq.size() - 1)] : 0;
      wrl = wr ? wq[$urandom_range(0, wq.size() - 1)] : 0;
      step(v, $urandom_range(0, 7), $urandom_range(0, 9) * BLK + $urandom_range(0, 63),
           $urandom_range(0, 16), rd, rdl, wr, wrl);
    end
    drain();

    // R12: let the watchdog disarm, then a held entry must trip R10 on schedule
    idle(3 * THRESH);
    req(0, 20, 0, 4);
    idle(2 * THRESH + 10);
    drain();
    idle(10);

    // R8: completion for a line absent from its own table
    req(2, 30, 0, 4);
    step(0, 0, 0, 0, 1, 30, 0, 0);
    idle(3);
    step(0, 0, 0, 0, 0, 0, 1, 30);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule